// File: doc/BRIEF.md
# Two-Port Shared Memory with Mailbox Interrupts

This block is a synchronous shared memory of 1024 words by 8 bits. It has two independent access ports, called left and right. Each port has a select, a write strobe, a read-output gate, a 10-bit address, write data, registered read data, an active-low busy flag and an active-low interrupt flag. Any port can reach any word. Both ports may read the same word in the same cycle.

A write collides with the other port when both ports are selected on the same address and at least one of them writes. The left port always wins a collision. The right port is flagged busy and its write is dropped. The two highest addresses are mailboxes. The top word belongs to the left port and the word below it belongs to the right port. A completed write by the other port into a mailbox stores the word and raises the owner's interrupt. The owner lowers the interrupt again by reading its mailbox.

A build-time mode picks the busy source. In master mode, collisions are detected inside the block and reported on the busy outputs. In slave mode, the busy flags come in from a master and block writes exactly as internal busy would. Two instances can then be operated side by side to form a wider word.

Top module: `dpram_mailbox`

## Requirements
- R1: A word written through either port at address A is returned by either port when A is later read. Read data appears on the clock edge after the one that samples the read request.
- R2: When both ports read the same address in the same cycle, both receive the stored word and neither busy flag asserts.
- R3: Read data is all zeros in the cycle after any cycle where the port is deselected, has its output gate low, or is writing.
- R4: In master mode, a collision is both ports selected on the same address with at least one writing. During a collision, the right busy output is 0 in that same cycle and the left busy output stays 1. With no collision, both busy outputs are 1.
- R5: In master mode, the right port's write is dropped during a collision. When both ports write the same address, the left data is stored.
- R6: A completed right-port write to address 0x3FF stores the data and drives the left interrupt output to 0 from the next edge. A left-port read of 0x3FF drives it back to 1 from the next edge, unless a completed right-port write to 0x3FF happens in that same cycle; in that case the interrupt stays low.
- R7: A completed left-port write to address 0x3FE stores the data and drives the right interrupt output to 0 from the next edge. A right-port read of 0x3FE drives it back to 1 from the next edge.
- R8: A port writing its own mailbox, or any non-mailbox address, changes neither interrupt output.
- R9: In slave mode, each busy output equals that port's busy input. A write from a port whose busy input is 0 is dropped. No collision is detected inside the block.
- R10: While reset is high, both interrupt outputs and both read data outputs return to 1, 1, 0 and 0 on the next edge.
- R11: In master mode, when the left port writes address A and the right port reads A in the same cycle, the right port returns the word held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_sel | input | 1 | Left port select |
| l_wen | input | 1 | Left write strobe (1 = write, 0 = read) |
| l_oen | input | 1 | Left read output gate |
| l_addr | input | 10 | Left address |
| l_wdata | input | 8 | Left write data |
| l_busy_in_n | input | 1 | Left busy from a master (slave mode only) |
| l_rdata | output | 8 | Left read data |
| l_busy_n | output | 1 | Left busy, active low |
| l_int_n | output | 1 | Left interrupt, active low |
| r_sel | input | 1 | Right port select |
| r_wen | input | 1 | Right write strobe (1 = write, 0 = read) |
| r_oen | input | 1 | Right read output gate |
| r_addr | input | 10 | Right address |
| r_wdata | input | 8 | Right write data |
| r_busy_in_n | input | 1 | Right busy from a master (slave mode only) |
| r_rdata | output | 8 | Right read data |
| r_busy_n | output | 1 | Right busy, active low |
| r_int_n | output | 1 | Right interrupt, active low |

## Verification
The bench builds two instances with the default 10-bit address and 8-bit data. One is in master mode and one is in slave mode, and both are driven by the same port stimulus. The default width puts the real mailbox addresses 0x3FF and 0x3FE in play, together with ordinary addresses next to them. The master instance covers collision arbitration, read-during-write ordering and the interrupt handshake. The slave instance shows that busy inputs alone gate its writes, even when the shared stimulus makes the master see a collision.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
   typedef enum logic {
      BUSY_SLAVE  = 1'b0,
      BUSY_MASTER = 1'b1
   } busy_mode_e;
endpackage

// File: rtl/dpram_arb.sv
module dpram_arb #(
   parameter int                     ADDR_W = 10,
   parameter dpram_pkg::busy_mode_e MODE   = dpram_pkg::BUSY_MASTER
) (
   input  logic              l_sel,
   input  logic              l_wen,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              l_busy_in_n,
   input  logic              r_sel,
   input  logic              r_wen,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              r_busy_in_n,
   output logic              l_busy,
   output logic              r_busy
);
   generate
      if (MODE == dpram_pkg::BUSY_MASTER) begin : g_master
         logic clash;
         logic unused_inputs;
         assign clash = l_sel && r_sel && (l_addr == r_addr) && (l_wen || r_wen);
         // the left side has fixed priority
         assign l_busy = 1'b0;
         assign r_busy = clash;
         assign unused_inputs = l_busy_in_n ^ r_busy_in_n;
      end else begin : g_slave
         logic unused_inputs;
         assign l_busy = !l_busy_in_n;
         assign r_busy = !r_busy_in_n;
         assign unused_inputs = ^{l_sel, l_wen, l_addr, r_sel, r_wen, r_addr};
      end
   endgenerate
endmodule

// File: rtl/dpram_core.sv
module dpram_core #(
   parameter  int ADDR_W = 10,
   parameter  int DATA_W = 8,
   localparam int DEPTH  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              l_we,
   input  logic              l_re,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              r_we,
   input  logic              r_re,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata
);
   logic [DATA_W-1:0] cells [DEPTH];

   // right side first so the left write lands last on a shared address
   always_ff @(posedge clk) begin
      if (r_we) cells[r_addr] <= r_wdata;
      if (l_we) cells[l_addr] <= l_wdata;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         l_rdata <= '0;
         r_rdata <= '0;
      end else begin
         l_rdata <= l_re ? cells[l_addr] : '0;
         r_rdata <= r_re ? cells[r_addr] : '0;
      end
   end
endmodule

// File: rtl/dpram_irq.sv
module dpram_irq (
   input  logic clk,
   input  logic rst,
   input  logic post,
   input  logic take,
   output logic irq_n
);
   logic pending;

   always_ff @(posedge clk) begin
      if (rst)       pending <= 1'b0;
      else if (post) pending <= 1'b1;
      else if (take) pending <= 1'b0;
   end

   assign irq_n = !pending;
endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox #(
   parameter int                     ADDR_W = 10,
   parameter int                     DATA_W = 8,
   parameter dpram_pkg::busy_mode_e MODE   = dpram_pkg::BUSY_MASTER
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              l_sel,
   input  logic              l_wen,
   input  logic              l_oen,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   input  logic              l_busy_in_n,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_busy_n,
   output logic              l_int_n,
   input  logic              r_sel,
   input  logic              r_wen,
   input  logic              r_oen,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   input  logic              r_busy_in_n,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_busy_n,
   output logic              r_int_n
);
   localparam logic [ADDR_W-1:0] L_BOX = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] R_BOX = L_BOX - 1'b1;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("dpram_mailbox: ADDR_W must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("dpram_mailbox: DATA_W must be at least 1");
      end
   endgenerate

   logic l_busy, r_busy;
   logic l_we, r_we, l_re, r_re;

   dpram_arb #(.ADDR_W(ADDR_W), .MODE(MODE)) u_arb (
      .l_sel(l_sel), .l_wen(l_wen), .l_addr(l_addr), .l_busy_in_n(l_busy_in_n),
      .r_sel(r_sel), .r_wen(r_wen), .r_addr(r_addr), .r_busy_in_n(r_busy_in_n),
      .l_busy(l_busy), .r_busy(r_busy)
   );

   assign l_we = l_sel && l_wen && !l_busy;
   assign r_we = r_sel && r_wen && !r_busy;
   assign l_re = l_sel && !l_wen && l_oen;
   assign r_re = r_sel && !r_wen && r_oen;

   dpram_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
      .clk(clk), .rst(rst),
      .l_we(l_we), .l_re(l_re), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
      .r_we(r_we), .r_re(r_re), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
   );

   dpram_irq u_irq_left (
      .clk(clk), .rst(rst),
      .post(r_we && (r_addr == L_BOX)),
      .take(l_sel && !l_wen && (l_addr == L_BOX)),
      .irq_n(l_int_n)
   );

   dpram_irq u_irq_right (
      .clk(clk), .rst(rst),
      .post(l_we && (l_addr == R_BOX)),
      .take(r_sel && !r_wen && (r_addr == R_BOX)),
      .irq_n(r_int_n)
   );

   assign l_busy_n = !l_busy;
   assign r_busy_n = !r_busy;
endmodule

// File: rtl/dpram_mailbox_chk.sv
module dpram_mailbox_chk #(
   parameter int                     ADDR_W = 10,
   parameter int                     DATA_W = 8,
   parameter dpram_pkg::busy_mode_e MODE   = dpram_pkg::BUSY_MASTER
) (
   input logic              clk,
   input logic              rst,
   input logic              l_sel,
   input logic              l_wen,
   input logic              l_oen,
   input logic [ADDR_W-1:0] l_addr,
   input logic              l_busy_in_n,
   input logic [DATA_W-1:0] l_rdata,
   input logic              l_busy_n,
   input logic              l_int_n,
   input logic              r_sel,
   input logic              r_wen,
   input logic              r_oen,
   input logic [ADDR_W-1:0] r_addr,
   input logic              r_busy_in_n,
   input logic [DATA_W-1:0] r_rdata,
   input logic              r_busy_n,
   input logic              r_int_n
);
   localparam logic [ADDR_W-1:0] L_BOX = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] R_BOX = L_BOX - 1'b1;

   assert_reset_idle_R10: assert property (@(posedge clk)
      rst |=> (l_int_n && r_int_n && l_rdata == '0 && r_rdata == '0));

   assert_l_rdata_zero_R3: assert property (@(posedge clk) disable iff (rst)
      !(l_sel && !l_wen && l_oen) |=> l_rdata == '0);

   assert_r_rdata_zero_R3: assert property (@(posedge clk) disable iff (rst)
      !(r_sel && !r_wen && r_oen) |=> r_rdata == '0);

   assert_l_int_post_R6: assert property (@(posedge clk) disable iff (rst)
      (r_sel && r_wen && r_busy_n && r_addr == L_BOX) |=> !l_int_n);

   assert_l_int_take_R6: assert property (@(posedge clk) disable iff (rst)
      (l_sel && !l_wen && l_addr == L_BOX && !(r_sel && r_wen && r_addr == L_BOX))
      |=> l_int_n);

   assert_r_int_post_R7: assert property (@(posedge clk) disable iff (rst)
      (l_sel && l_wen && l_busy_n && l_addr == R_BOX) |=> !r_int_n);

   assert_l_int_cause_R8: assert property (@(posedge clk) disable iff (rst)
      $fell(l_int_n) |-> $past(r_sel && r_wen && r_addr == L_BOX));

   assert_r_int_cause_R8: assert property (@(posedge clk) disable iff (rst)
      $fell(r_int_n) |-> $past(l_sel && l_wen && l_addr == R_BOX));

   generate
      if (MODE == dpram_pkg::BUSY_MASTER) begin : g_master_chk
         assert_busy_clash_R4: assert property (@(posedge clk) disable iff (rst)
            (l_sel && r_sel && l_addr == r_addr && (l_wen || r_wen))
            |-> (!r_busy_n && l_busy_n));
         assert_busy_quiet_R4: assert property (@(posedge clk) disable iff (rst)
            !(l_sel && r_sel && l_addr == r_addr && (l_wen || r_wen))
            |-> (l_busy_n && r_busy_n));
      end else begin : g_slave_chk
         assert_busy_follow_R9: assert property (@(posedge clk) disable iff (rst)
            (l_busy_n == l_busy_in_n) && (r_busy_n == r_busy_in_n));
      end
   endgenerate
endmodule

bind dpram_mailbox dpram_mailbox_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE(MODE)) u_chk (
   .clk(clk), .rst(rst),
   .l_sel(l_sel), .l_wen(l_wen), .l_oen(l_oen), .l_addr(l_addr),
   .l_busy_in_n(l_busy_in_n), .l_rdata(l_rdata), .l_busy_n(l_busy_n), .l_int_n(l_int_n),
   .r_sel(r_sel), .r_wen(r_wen), .r_oen(r_oen), .r_addr(r_addr),
   .r_busy_in_n(r_busy_in_n), .r_rdata(r_rdata), .r_busy_n(r_busy_n), .r_int_n(r_int_n)
);

// File: tb/dpram_mailbox_bench.sv
module dpram_mailbox_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       l_sel = 0, l_wen = 0, l_oen = 0, l_bi_n = 1;
   logic       r_sel = 0, r_wen = 0, r_oen = 0, r_bi_n = 1;
   logic [9:0] l_addr = '0, r_addr = '0;
   logic [7:0] l_wdata = '0, r_wdata = '0;
   logic [7:0] m_l_rd, m_r_rd, s_l_rd, s_r_rd;
   logic       m_l_bn, m_r_bn, m_l_in, m_r_in;
   logic       s_l_bn, s_r_bn, s_l_in, s_r_in;
   int         checks = 0;
   int         fails  = 0;
   bit         done   = 0;

   always #4 clk = ~clk;

   dpram_mailbox #(.ADDR_W(10), .DATA_W(8), .MODE(dpram_pkg::BUSY_MASTER)) u_dpram_mailbox (
      .clk(clk), .rst(rst),
      .l_sel(l_sel), .l_wen(l_wen), .l_oen(l_oen), .l_addr(l_addr), .l_wdata(l_wdata),
      .l_busy_in_n(l_bi_n), .l_rdata(m_l_rd), .l_busy_n(m_l_bn), .l_int_n(m_l_in),
      .r_sel(r_sel), .r_wen(r_wen), .r_oen(r_oen), .r_addr(r_addr), .r_wdata(r_wdata),
      .r_busy_in_n(r_bi_n), .r_rdata(m_r_rd), .r_busy_n(m_r_bn), .r_int_n(m_r_in)
   );

   dpram_mailbox #(.ADDR_W(10), .DATA_W(8), .MODE(dpram_pkg::BUSY_SLAVE)) u_dpram_mailbox_slave (
      .clk(clk), .rst(rst),
      .l_sel(l_sel), .l_wen(l_wen), .l_oen(l_oen), .l_addr(l_addr), .l_wdata(l_wdata),
      .l_busy_in_n(l_bi_n), .l_rdata(s_l_rd), .l_busy_n(s_l_bn), .l_int_n(s_l_in),
      .r_sel(r_sel), .r_wen(r_wen), .r_oen(r_oen), .r_addr(r_addr), .r_wdata(r_wdata),
      .r_busy_in_n(r_bi_n), .r_rdata(s_r_rd), .r_busy_n(s_r_bn), .r_int_n(s_r_in)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic lport(input logic s, input logic w, input logic o, input int a, input int d);
      l_sel = s; l_wen = w; l_oen = o; l_addr = a[9:0]; l_wdata = d[7:0];
   endtask

   task automatic rport(input logic s, input logic w, input logic o, input int a, input int d);
      r_sel = s; r_wen = w; r_oen = o; r_addr = a[9:0]; r_wdata = d[7:0];
   endtask

   task automatic quiet();
      lport(0, 0, 0, 0, 0);
      rport(0, 0, 0, 0, 0);
   endtask

   task automatic t_reset();
      check("R10", "left int", m_l_in, 1);
      check("R10", "right int", m_r_in, 1);
      check("R10", "left rdata", m_l_rd, 0);
      check("R10", "right rdata", m_r_rd, 0);
      check("R4", "idle busy", {m_l_bn, m_r_bn}, 2'b11);
   endtask

   task automatic t_basic_rw();
      lport(1, 1, 0, 'h012, 'hA5); rport(1, 1, 0, 'h200, 'h3C); step();
      lport(1, 1, 0, 'h000, 'h5A); rport(1, 1, 0, 'h3FD, 'hC3); step();
      lport(1, 0, 1, 'h200, 0);    rport(1, 0, 1, 'h012, 0);    step();
      check("R1", "left reads right's word", m_l_rd, 'h3C);
      check("R1", "right reads left's word", m_r_rd, 'hA5);
      lport(1, 0, 1, 'h3FD, 0);    rport(1, 0, 1, 'h000, 0);    step();
      check("R1", "left reads 0x3FD", m_l_rd, 'hC3);
      check("R1", "right reads 0x000", m_r_rd, 'h5A);
      check("R8", "plain writes leave ints", {m_l_in, m_r_in}, 2'b11);
      quiet();
   endtask

   task automatic t_dual_read();
      lport(1, 0, 1, 'h012, 0); rport(1, 0, 1, 'h012, 0);
      #1 check("R2", "shared read busy", {m_l_bn, m_r_bn}, 2'b11);
      step();
      check("R2", "left shared read", m_l_rd, 'hA5);
      check("R2", "right shared read", m_r_rd, 'hA5);
      quiet();
   endtask

   task automatic t_idle();
      lport(0, 0, 1, 'h012, 0); rport(1, 0, 0, 'h012, 0); step();
      check("R3", "left deselected", m_l_rd, 0);
      check("R3", "right gate low", m_r_rd, 0);
      lport(1, 1, 1, 'h100, 'h77); rport(1, 0, 1, 'h012, 0); step();
      check("R3", "left writing", m_l_rd, 0);
      check("R1", "right still reads", m_r_rd, 'hA5);
      quiet();
   endtask

   task automatic t_clash();
      lport(1, 1, 0, 'h050, 'h11); rport(1, 1, 0, 'h050, 'h22);
      #1 check("R4", "write-write busy", {m_l_bn, m_r_bn}, 2'b10);
      step();
      lport(1, 0, 1, 'h050, 0); rport(1, 1, 0, 'h050, 'h33);
      #1 check("R4", "read-write busy", {m_l_bn, m_r_bn}, 2'b10);
      step();
      check("R5", "left wins both-write", m_l_rd, 'h11);
      lport(1, 0, 1, 'h050, 0); rport(0, 0, 0, 0, 0); step();
      check("R5", "right write dropped", m_l_rd, 'h11);
      lport(1, 1, 0, 'h051, 'h01); rport(1, 1, 0, 'h052, 'h02);
      #1 check("R4", "distinct addresses no busy", {m_l_bn, m_r_bn}, 2'b11);
      step();
      lport(1, 0, 1, 'h052, 0); rport(1, 0, 1, 'h051, 0); step();
      check("R1", "distinct writes kept", {m_l_rd, m_r_rd}, 'h0201);
      quiet();
   endtask

   task automatic t_read_during_write();
      lport(1, 1, 0, 'h060, 'h44); step();
      lport(1, 1, 0, 'h060, 'h55); rport(1, 0, 1, 'h060, 0);
      #1 check("R4", "right read vs left write busy", m_r_bn, 0);
      step();
      check("R11", "right sees old word", m_r_rd, 'h44);
      lport(0, 0, 0, 0, 0); rport(1, 0, 1, 'h060, 0); step();
      check("R11", "new word after", m_r_rd, 'h55);
      quiet();
   endtask

   task automatic t_left_box();
      rport(1, 1, 0, 'h3FF, 'h9A); step();
      check("R6", "left int raised", m_l_in, 0);
      check("R8", "right int untouched", m_r_in, 1);
      rport(0, 0, 0, 0, 0); step();
      check("R6", "left int held", m_l_in, 0);
      lport(1, 0, 1, 'h3FF, 0); step();
      check("R6", "mailbox data", m_l_rd, 'h9A);
      check("R6", "left int cleared", m_l_in, 1);
      quiet();
   endtask

   task automatic t_right_box();
      lport(1, 1, 0, 'h3FE, 'h6B); step();
      check("R7", "right int raised", m_r_in, 0);
      check("R8", "left int untouched", m_l_in, 1);
      lport(0, 0, 0, 0, 0); rport(1, 0, 1, 'h3FE, 0); step();
      check("R7", "mailbox data", m_r_rd, 'h6B);
      check("R7", "right int cleared", m_r_in, 1);
      quiet();
   endtask

   task automatic t_own_box();
      lport(1, 1, 0, 'h3FF, 'h12); step();
      lport(0, 0, 0, 0, 0); rport(1, 1, 0, 'h3FE, 'h34); step();
      check("R8", "own mailbox writes", {m_l_in, m_r_in}, 2'b11);
      quiet();
   endtask

   task automatic t_slave();
      lport(1, 1, 0, 'h010, 'h77); step();
      r_bi_n = 0; lport(0, 0, 0, 0, 0); rport(1, 1, 0, 'h010, 'h88);
      #1 check("R9", "slave busy follows inputs", {s_l_bn, s_r_bn}, 2'b10);
      step();
      r_bi_n = 1; rport(1, 0, 1, 'h010, 0); step();
      check("R9", "slave write blocked by busy input", s_r_rd, 'h77);
      lport(1, 1, 0, 'h020, 'hAB); rport(1, 1, 0, 'h021, 'hCD);
      l_addr = 10'h021;
      #1 check("R9", "no internal clash in slave", {s_l_bn, s_r_bn}, 2'b11);
      check("R4", "master sees clash", {m_l_bn, m_r_bn}, 2'b10);
      step();
      l_bi_n = 0; lport(1, 1, 0, 'h022, 'hEE); rport(0, 0, 0, 0, 0);
      #1 check("R9", "left busy input", s_l_bn, 0);
      step();
      l_bi_n = 1; lport(1, 0, 1, 'h021, 0); rport(1, 0, 1, 'h022, 0); step();
      check("R9", "left wins when both write", s_l_rd, 'hAB);
      check("R9", "left write blocked", s_r_rd == 8'hEE, 0);
      quiet();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst = 0;
      t_reset();
      t_basic_rw();
      t_dual_read();
      t_idle();
      t_clash();
      t_read_during_write();
      t_left_box();
      t_right_box();
      t_own_box();
      t_slave();
      step();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule